// File: doc/BRIEF.md
# Streaming LFSR / CRC Unit

This unit sits in the byte path of one transfer channel. Every byte that moves through it is folded into a shift register. The register's feedback polynomial, its active length (1 to 16 bits) and its starting value are set at run time. In pass mode the bytes leave unchanged and the register builds up a checksum over the stream. In append mode each outgoing byte is taken from the updated register instead of the incoming byte. A constant input therefore produces a pseudorandom byte sequence, which makes the unit usable as a noise source.

Both sides of the unit are byte-wide valid/ready streams. There is one output register stage. A single-cycle load pulse copies the seed into the register, so a sequence can be restarted and repeated. The current register contents are always visible on a port.

Top module: `crc_stream_unit`

## Requirements
- R1: While reset is asserted and after it is released, out_valid is 0 and crc_value is 0 until the first load or accepted byte.
- R2: In the cycle after a cycle with cfg_load high, crc_value equals cfg_seed masked to the programmed length, whatever the input stream does.
- R3: An accepted byte updates the register one bit at a time, MSB first. Each step first computes a feedback bit as register bit (cfg_len_m1) XOR the data bit. It then shifts the register left by one and, if the feedback bit was 1, XORs in cfg_poly. Finally it masks the result to the length.
- R4: After every load or update, all register bits at positions above cfg_len_m1 are 0. The active length is cfg_len_m1+1.
- R5: With cfg_append at 0, the byte presented on out_data equals the accepted input byte.
- R6: With cfg_append at 1, the byte presented on out_data equals bits 7..0 of the register value after that byte's update.
- R7: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data does not change. No accepted byte is lost or repeated.
- R8: in_ready is 1 exactly when cfg_load is 0 and either out_valid is 0 or out_ready is 1.
- R9: In a cycle with no load and no accepted byte, crc_value does not change, even if cfg_poly, cfg_seed, cfg_append or cfg_len_m1 change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_poly | input | 16 | Feedback polynomial |
| cfg_len_m1 | input | 4 | Register length minus one |
| cfg_seed | input | 16 | Starting value loaded by cfg_load |
| cfg_append | input | 1 | 1: output carries register byte; 0: pass data |
| cfg_load | input | 1 | Load seed into the register this cycle |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Unit accepts a byte this cycle |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Downstream accepts the output byte |
| crc_value | output | 16 | Current register contents |

## Verification
The properties assume that cfg_len_m1 and cfg_poly keep their values from one update to the next while a checksum is being built. They also assume that the downstream side does not expect a byte to be offered in a load cycle. The stimulus changes configuration only in idle stretches or together with a load, and mixes several backpressure patterns on out_ready. A behavioural model in the bench tracks the register and the output stage every cycle. It is driven through the lengths 16, 5 and 1, through both modes, and through a seed reload that repeats an earlier sequence.

// File: rtl/crc_stream_pkg.sv
package crc_stream_pkg;
  typedef enum logic {
    MODE_PASS   = 1'b0,
    MODE_APPEND = 1'b1
  } out_mode_e;
endpackage

// File: rtl/crc_len_mask.sv
module crc_len_mask #(
  parameter int CRC_W = 16,
  localparam int LW = $clog2(CRC_W)
) (
  input  logic [LW-1:0]    len_m1,
  output logic [CRC_W-1:0] mask
);
  for (genvar gi = 0; gi < CRC_W; gi++) begin : g_bit
    assign mask[gi] = (LW'(gi) <= len_m1);
  end
endmodule

// File: rtl/crc_bit_step.sv
module crc_bit_step #(
  parameter int CRC_W = 16,
  localparam int LW = $clog2(CRC_W)
) (
  input  logic [CRC_W-1:0] cur,
  input  logic [CRC_W-1:0] poly,
  input  logic [CRC_W-1:0] mask,
  input  logic [LW-1:0]    tap_idx,
  input  logic             din,
  output logic [CRC_W-1:0] nxt
);
  logic             fb;
  logic [CRC_W-1:0] shifted;

  always_comb begin
    fb      = cur[tap_idx] ^ din;
    shifted = {cur[CRC_W-2:0], 1'b0};
    nxt     = (fb ? (shifted ^ poly) : shifted) & mask;
  end
endmodule

// File: rtl/crc_byte_engine.sv
module crc_byte_engine #(
  parameter int CRC_W = 16,
  parameter int DW    = 8,
  localparam int LW = $clog2(CRC_W)
) (
  input  logic [CRC_W-1:0] cur,
  input  logic [CRC_W-1:0] poly,
  input  logic [CRC_W-1:0] mask,
  input  logic [LW-1:0]    tap_idx,
  input  logic [DW-1:0]    din,
  output logic [CRC_W-1:0] nxt
);
  logic [CRC_W-1:0] chain [DW+1];

  assign chain[0] = cur;

  for (genvar gs = 0; gs < DW; gs++) begin : g_step
    crc_bit_step #(.CRC_W(CRC_W)) i_step (
      .cur     (chain[gs]),
      .poly    (poly),
      .mask    (mask),
      .tap_idx (tap_idx),
      .din     (din[DW-1-gs]),
      .nxt     (chain[gs+1])
    );
  end

  assign nxt = chain[DW];
endmodule

// File: rtl/crc_stream_unit.sv
module crc_stream_unit #(
  parameter int CRC_W = 16,
  parameter int DW    = 8,
  localparam int LW = $clog2(CRC_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CRC_W-1:0] cfg_poly,
  input  logic [LW-1:0]    cfg_len_m1,
  input  logic [CRC_W-1:0] cfg_seed,
  input  logic             cfg_append,
  input  logic             cfg_load,
  input  logic             in_valid,
  input  logic [DW-1:0]    in_data,
  output logic             in_ready,
  output logic             out_valid,
  output logic [DW-1:0]    out_data,
  input  logic             out_ready,
  output logic [CRC_W-1:0] crc_value
);
  import crc_stream_pkg::*;

  logic [CRC_W-1:0] len_mask;
  logic [CRC_W-1:0] stepped;
  logic [CRC_W-1:0] state_q, state_d;
  logic             state_en;
  logic             ov_q, ov_d;
  logic [DW-1:0]    od_q, od_d;
  logic             accept;
  out_mode_e        mode;

  crc_len_mask #(.CRC_W(CRC_W)) i_mask (
    .len_m1 (cfg_len_m1),
    .mask   (len_mask)
  );

  crc_byte_engine #(.CRC_W(CRC_W), .DW(DW)) i_engine (
    .cur     (state_q),
    .poly    (cfg_poly),
    .mask    (len_mask),
    .tap_idx (cfg_len_m1),
    .din     (in_data),
    .nxt     (stepped)
  );

  assign mode     = out_mode_e'(cfg_append);
  assign in_ready = !cfg_load && (!ov_q || out_ready);
  assign accept   = in_valid && in_ready;

  always_comb begin
    state_en = cfg_load || accept;
    state_d  = state_q;
    if (cfg_load) begin
      state_d = cfg_seed & len_mask;
    end else if (accept) begin
      state_d = stepped;
    end
  end

  always_comb begin
    ov_d = ov_q;
    od_d = od_q;
    if (accept) begin
      ov_d = 1'b1;
      od_d = (mode == MODE_APPEND) ? stepped[DW-1:0] : in_data;
    end else if (out_ready) begin
      ov_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      od_q <= '0;
    end else begin
      ov_q <= ov_d;
      if (accept) begin
        od_q <= od_d;
      end
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign crc_value = state_q;
endmodule

// File: rtl/crc_stream_checker.sv
module crc_stream_checker #(
  parameter int CRC_W = 16,
  parameter int DW    = 8,
  localparam int LW = $clog2(CRC_W)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CRC_W-1:0] cfg_seed,
  input logic [LW-1:0]    cfg_len_m1,
  input logic             cfg_append,
  input logic             cfg_load,
  input logic             in_valid,
  input logic [DW-1:0]    in_data,
  input logic             in_ready,
  input logic             out_valid,
  input logic [DW-1:0]    out_data,
  input logic             out_ready,
  input logic [CRC_W-1:0] crc_value
);
  function automatic logic [CRC_W-1:0] width_mask(input logic [LW-1:0] lm1);
    logic [CRC_W-1:0] m;
    for (int k = 0; k < CRC_W; k++) m[k] = (k <= int'(lm1));
    return m;
  endfunction

  logic took;
  assign took = in_valid && in_ready;

  p_seed_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> crc_value == ($past(cfg_seed) & width_mask($past(cfg_len_m1))));

  p_len_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load || took) |=> (crc_value & ~width_mask($past(cfg_len_m1))) == '0);

  p_pass_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (took && !cfg_append) |=> (out_valid && out_data == $past(in_data)));

  p_hold_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_load_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |-> !in_ready);

  p_idle_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_load && !took) |=> $stable(crc_value));
endmodule

bind crc_stream_unit crc_stream_checker #(.CRC_W(CRC_W), .DW(DW)) i_crc_stream_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_seed   (cfg_seed),
  .cfg_len_m1 (cfg_len_m1),
  .cfg_append (cfg_append),
  .cfg_load   (cfg_load),
  .in_valid   (in_valid),
  .in_data    (in_data),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_data   (out_data),
  .out_ready  (out_ready),
  .crc_value  (crc_value)
);

// File: tb/test_crc_stream_unit.sv
module test_crc_stream_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cfg_poly, cfg_seed, crc_value;
  logic [3:0]  cfg_len_m1;
  logic        cfg_append, cfg_load, in_valid, in_ready, out_valid, out_ready;
  logic [7:0]  in_data, out_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  crc_stream_unit i_crc_stream_unit (
    .clk(clk), .rst_n(rst_n), .cfg_poly(cfg_poly), .cfg_len_m1(cfg_len_m1),
    .cfg_seed(cfg_seed), .cfg_append(cfg_append), .cfg_load(cfg_load),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .crc_value(crc_value)
  );

  // Reference model, behavioural
  logic [15:0] m_state;
  logic        m_ov;
  logic [7:0]  m_od;
  bit          cmp_on = 0;

  function automatic logic [15:0] ref_mask(input int len);
    logic [15:0] m = '0;
    for (int k = 0; k < len; k++) m[k] = 1'b1;
    return m;
  endfunction

  function automatic logic [15:0] ref_byte(input logic [15:0] s, input logic [7:0] d,
                                           input logic [15:0] p, input int len);
    logic fb;
    for (int i = 7; i >= 0; i--) begin
      fb = s[len-1] ^ d[i];
      s  = s << 1;
      if (fb) s = s ^ p;
      s  = s & ref_mask(len);
    end
    return s;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state <= '0; m_ov <= 1'b0; m_od <= '0;
    end else begin
      logic rdy;
      logic [15:0] ns;
      rdy = !cfg_load && (!m_ov || out_ready);
      ns  = ref_byte(m_state, in_data, cfg_poly, int'(cfg_len_m1) + 1);
      if (cfg_load) m_state <= cfg_seed & ref_mask(int'(cfg_len_m1) + 1);
      else if (in_valid && rdy) m_state <= ns;
      if (in_valid && rdy) begin
        m_ov <= 1'b1;
        m_od <= cfg_append ? ns[7:0] : in_data;
      end else if (out_ready) m_ov <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, 3 ns after the rising edge
  always @(posedge clk) begin
    #3;
    if (cmp_on && rst_n) begin
      logic er;
      er = !cfg_load && (!m_ov || out_ready);
      check(crc_value == m_state, "R3 register", crc_value, m_state);
      check(out_valid == m_ov, "R7 out_valid", out_valid, m_ov);
      check(in_ready == er, "R8 in_ready", in_ready, er);
      if (m_ov) check(out_data == m_od, cfg_append ? "R6 append byte" : "R5 pass byte",
                      out_data, m_od);
    end
  end

  task automatic run(input int n, input int pat, input bit vary);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      in_valid  = vary ? (((c * 7 + pat) % 5) != 0) : 1'b1;
      in_data   = vary ? 8'((c * 37 + pat * 11) ^ (c >> 1)) : 8'h00;
      out_ready = (pat == 0) ? 1'b1 : (((c + pat) % 3) != 0);
    end
  endtask

  task automatic load(input logic [15:0] seed, input logic [15:0] poly,
                      input logic [3:0] lm1, input bit app);
    @(negedge clk);
    cfg_seed = seed; cfg_poly = poly; cfg_len_m1 = lm1; cfg_append = app;
    cfg_load = 1'b1; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0; in_valid = 1'b0;
    check(crc_value == (seed & ref_mask(int'(lm1) + 1)), "R2 seed load", crc_value,
          seed & ref_mask(int'(lm1) + 1));
  endtask

  logic [7:0] first_run [8];

  initial begin
    rst_n = 1'b0; cfg_poly = 16'ha010; cfg_seed = 16'hffff; cfg_len_m1 = 4'd15;
    cfg_append = 1'b0; cfg_load = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check(out_valid == 1'b0 && crc_value == 16'h0, "R1 in reset", {out_valid, crc_value}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && crc_value == 16'h0, "R1 after release",
          {out_valid, crc_value}, 0);
    cmp_on = 1;

    // Noise source: constant zero input, append mode, length 16
    load(16'hffff, 16'ha010, 4'd15, 1'b1);
    for (int c = 0; c < 8; c++) begin
      @(negedge clk); in_valid = 1'b1; in_data = 8'h00; out_ready = 1'b1;
      @(negedge clk); first_run[c] = out_data; in_valid = 1'b0;
    end
    run(40, 0, 1'b0);
    check(crc_value != 16'h0 && crc_value != 16'hffff, "R6 sequence runs", crc_value, 0);

    // Seed reload restarts the same sequence
    in_valid = 1'b0;
    load(16'hffff, 16'ha010, 4'd15, 1'b1);
    for (int c = 0; c < 8; c++) begin
      @(negedge clk); in_valid = 1'b1; in_data = 8'h00; out_ready = 1'b1;
      @(negedge clk); in_valid = 1'b0;
      check(out_data == first_run[c], "R2 repeat after reload", out_data, first_run[c]);
    end

    // Pass mode, varied data and backpressure
    load(16'h1d0f, 16'h1021, 4'd15, 1'b0);
    run(60, 1, 1'b1);
    run(60, 2, 1'b1);

    // Held output under backpressure (R7)
    @(negedge clk); in_valid = 1'b1; in_data = 8'h5a; out_ready = 1'b0;
    @(negedge clk); in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid && out_data == 8'h5a, "R7 held byte", out_data, 8'h5a);
    out_ready = 1'b1;

    // Short length 5 with append
    load(16'hffff, 16'h0012, 4'd4, 1'b1);
    run(50, 3, 1'b1);
    @(negedge clk); in_valid = 1'b0;
    check((crc_value >> 5) == 0, "R4 length 5 mask", crc_value, crc_value & 16'h1f);

    // Length 1
    load(16'h0003, 16'h0001, 4'd0, 1'b0);
    run(30, 1, 1'b1);
    @(negedge clk); in_valid = 1'b0;
    check((crc_value >> 1) == 0, "R4 length 1 mask", crc_value, crc_value & 16'h1);

    // Idle with config changes (R9)
    load(16'hbeef, 16'ha010, 4'd15, 1'b0);
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      in_valid = 1'b0; cfg_poly = 16'(c * 4099); cfg_seed = 16'(c * 77);
      cfg_append = c[0]; cfg_len_m1 = 4'(c + 3);
    end
    @(negedge clk);
    check(crc_value == 16'hbeef, "R9 idle unchanged", crc_value, 16'hbeef);
    cfg_len_m1 = 4'd15; cfg_poly = 16'ha010;
    run(20, 2, 1'b1);

    @(negedge clk); in_valid = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule